// File: doc/BRIEF.md
# Pipelined Full-Circle Sine and Cosine Generator

The block turns a stream of angles into sine and cosine values, one angle per clock. An angle is a W-bit binary-radian code in which 2^W codes make one full turn, so every code is a valid angle and any quadrant may be presented. After a fixed latency the block drives two signed fixed-point words. Their scale is MAG·2^FRAC, so with the default MAG = 1.0 and FRAC = W-2 a unit value uses two bits for sign and integer part and the remaining bits for the fraction.

The first stage registers each angle together with a start vector. Angles in the second or third quadrant are folded into the convergent half-plane: the start vector is negated and the angle's top bit is inverted. The start vector is the constant MAG/G·2^FRAC, rounded, where G is the CORDIC length growth of ITER iterations, so no gain correction is needed at the output. ITER rotation-mode iterations follow, and each one is registered. An iteration shifts by its own index, and the sign of its residual angle picks the turn direction. Cosine comes out of the X path and sine out of the Y path.

Top module: `sincos_pipe`

## Requirements
- R1: For angles whose top two bits are equal (first and fourth quadrant), `cos_o` equals round(MAG·2^FRAC·cos(2π·ang/2^W)) within ITER+2 LSB.
- R2: For the same angles, `sin_o` equals round(MAG·2^FRAC·sin(2π·ang/2^W)) within ITER+2 LSB.
- R3: An angle sampled on a rising clock edge produces its result after exactly ITER+1 rising edges. The value on the output at the edge before that still belongs to the previous angle. One result emerges per clock, in input order.
- R4: Angles whose top two bits differ (second and third quadrant) meet the same accuracy as R1/R2. Well inside a quadrant (bits W-3 and W-4 differ), the output signs follow the quadrant: 00 gives +sin and +cos, 01 gives +sin and −cos, 10 gives −sin and −cos, 11 gives −sin and +cos.
- R5: Neither output magnitude ever exceeds MAG·2^FRAC + ITER+4 LSB.
- R6: While `rst` equals RST_LVL, both outputs are 0. This holds right after the reset is asserted, without any clock edge.
- R7: The axis angles 0, 2^(W-2), 2^(W-1) and 3·2^(W-2) give (cos, sin) of (+F, 0), (0, +F), (−F, 0) and (0, −F), with F = MAG·2^FRAC, within tolerance.
- R8: The same angle presented on consecutive clocks yields bit-identical consecutive results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous reset, active when equal to RST_LVL |
| ang | input | W | Angle in binary radians, 2^W codes per turn |
| sin_o | output | W | Signed sine, scaled by MAG·2^FRAC |
| cos_o | output | W | Signed cosine, scaled by MAG·2^FRAC |

## Verification
Quadrant folding of a freshly registered angle happens in the same cycle as the completion of an earlier angle from the opposite side of the fold. A fold error would therefore show as corruption of a neighbour in flight. The bench provokes this with a coarse sweep whose consecutive angles land in different quadrants, and with a hard switch from angle 0 to the half-turn code. Every emerging result is compared against a real-valued sine and cosine of the angle that entered ITER+1 clocks earlier. A reset asserted mid-stream is also checked at the outputs before the next clock edge.

// File: rtl/sincos_pipe.sv
module sincos_pipe #(
  parameter int  W       = 16,
  parameter int  ITER    = 14,
  parameter int  FRAC    = 14,
  parameter real MAG     = 1.0,
  parameter bit  RST_LVL = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] ang,
  output logic signed [W-1:0] sin_o,
  output logic signed [W-1:0] cos_o
);
  localparam real PI = 3.14159265358979323846;

  function automatic logic [ITER*W-1:0] mk_atan();
    logic [ITER*W-1:0] t;
    int k;
    t = '0;
    for (int i = 0; i < ITER; i++) begin
      k = $rtoi($atan(2.0 ** (-i)) / (2.0 * PI) * (2.0 ** W) + 0.5);
      t[i*W +: W] = k[W-1:0];
    end
    return t;
  endfunction

  function automatic int start_x();
    real g;
    g = 1.0;
    for (int i = 0; i < ITER; i++) g = g * $sqrt(1.0 + 2.0 ** (-2 * i));
    return $rtoi(MAG / g * (2.0 ** FRAC) + 0.5);
  endfunction

  localparam logic [ITER*W-1:0] ATAN = mk_atan();
  localparam int                X0I  = start_x();
  localparam logic signed [W-1:0] X0 = X0I[W-1:0];

  wire arst = (rst == RST_LVL);
  wire flip = ang[W-1] ^ ang[W-2];

  logic signed [W-1:0] xs [0:ITER];
  logic signed [W-1:0] ys [0:ITER];
  logic signed [W-1:0] zs [0:ITER];
  logic signed [W-1:0] xn [1:ITER];
  logic signed [W-1:0] yn [1:ITER];
  logic signed [W-1:0] zn [1:ITER];

  always_comb begin
    for (int i = 0; i < ITER; i++) begin
      if (zs[i][W-1]) begin
        xn[i+1] = xs[i] + (ys[i] >>> i);
        yn[i+1] = ys[i] - (xs[i] >>> i);
        zn[i+1] = zs[i] + $signed(ATAN[i*W +: W]);
      end else begin
        xn[i+1] = xs[i] - (ys[i] >>> i);
        yn[i+1] = ys[i] + (xs[i] >>> i);
        zn[i+1] = zs[i] - $signed(ATAN[i*W +: W]);
      end
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      for (int k = 0; k <= ITER; k++) begin
        xs[k] <= '0;
        ys[k] <= '0;
        zs[k] <= '0;
      end
    end else begin
      xs[0] <= flip ? -X0 : X0;
      ys[0] <= '0;
      zs[0] <= {ang[W-1] ^ flip, ang[W-2:0]};
      for (int k = 1; k <= ITER; k++) begin
        xs[k] <= xn[k];
        ys[k] <= yn[k];
        zs[k] <= zn[k];
      end
    end
  end

  assign cos_o = xs[ITER];
  assign sin_o = ys[ITER];
endmodule

// File: rtl/sincos_pipe_chk.sv
module sincos_pipe_chk #(
  parameter int  W       = 16,
  parameter int  ITER    = 14,
  parameter int  FRAC    = 14,
  parameter real MAG     = 1.0,
  parameter bit  RST_LVL = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic signed [W-1:0] ang,
  input logic signed [W-1:0] sin_v,
  input logic signed [W-1:0] cos_v
);
  localparam int LAT  = ITER + 1;
  localparam int FULL = $rtoi(MAG * (2.0 ** FRAC) + 0.5);
  localparam int TOL  = ITER + 4;

  wire arst = (rst == RST_LVL);
  logic [W-1:0] dly [0:LAT];
  int cnt;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      cnt <= 0;
      for (int k = 0; k <= LAT; k++) dly[k] <= '0;
    end else begin
      if (cnt < LAT + 1) cnt <= cnt + 1;
      dly[0] <= ang;
      for (int k = 1; k <= LAT; k++) dly[k] <= dly[k-1];
    end
  end

  wire [W-1:0] cur   = dly[ITER];
  wire [W-1:0] prv   = dly[LAT];
  wire         valid = (cnt >= LAT);
  wire         mid   = cur[W-3] ^ cur[W-4];
  wire         neg_c = cur[W-1] ^ cur[W-2];
  int abs_s, abs_c;
  always_comb begin
    abs_s = (sin_v < 0) ? -int'(sin_v) : int'(sin_v);
    abs_c = (cos_v < 0) ? -int'(cos_v) : int'(cos_v);
  end

  p_quad_sign_r4: assert property (@(posedge clk) disable iff (arst)
    (valid && mid) |-> (sin_v[W-1] == cur[W-1]) && (cos_v[W-1] == neg_c)
                       && (sin_v != 0) && (cos_v != 0));

  p_range_r5: assert property (@(posedge clk) disable iff (arst)
    (abs_s <= FULL + TOL) && (abs_c <= FULL + TOL));

  p_zero_angle_r7: assert property (@(posedge clk) disable iff (arst)
    (valid && cur == '0) |-> (int'(cos_v) >= FULL - TOL) && (abs_s <= TOL));

  p_repeat_stable_r8: assert property (@(posedge clk) disable iff (arst)
    (cnt == LAT + 1 && cur == prv) |-> ($stable(sin_v) && $stable(cos_v)));
endmodule

bind sincos_pipe sincos_pipe_chk #(
  .W(W), .ITER(ITER), .FRAC(FRAC), .MAG(MAG), .RST_LVL(RST_LVL)
) chk (
  .clk(clk), .rst(rst), .ang(ang), .sin_v(sin_o), .cos_v(cos_o)
);

// File: tb/sincos_pipe_test.sv
module sincos_pipe_test;
  localparam int  W    = 16;
  localparam int  ITER = 14;
  localparam int  FRAC = 14;
  localparam real MAG  = 1.0;
  localparam bit  RLV  = 1'b1;
  localparam int  LAT  = ITER + 1;
  localparam int  TOL  = ITER + 2;
  localparam real PI   = 3.14159265358979323846;
  localparam int  F    = 16384;

  logic clk = 1'b0;
  logic rst = RLV;
  logic signed [W-1:0] ang = '0;
  logic signed [W-1:0] sin_o, cos_o;
  int s_sin, s_cos;
  int total = 0, bad = 0;

  sincos_pipe #(.W(W), .ITER(ITER), .FRAC(FRAC), .MAG(MAG), .RST_LVL(RLV)) uut (
    .clk(clk), .rst(rst), .ang(ang), .sin_o(sin_o), .cos_o(cos_o));

  always #2 clk = ~clk;

  function automatic int ref_val(bit want_sin, logic [W-1:0] a);
    real th, v;
    th = 2.0 * PI * real'(a) / (2.0 ** W);
    v  = MAG * (2.0 ** FRAC) * (want_sin ? $sin(th) : $cos(th));
    return $rtoi(v + ((v >= 0.0) ? 0.5 : -0.5));
  endfunction

  task automatic chk(string tag, int act, int exp, int tol);
    int d;
    d = act - exp;
    if (d < 0) d = -d;
    total++;
    if (d > tol) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic step(logic [W-1:0] a);
    @(negedge clk);
    s_sin = int'(sin_o);
    s_cos = int'(cos_o);
    ang = a;
  endtask

  task automatic t_reset_start();
    rst = RLV;
    repeat (5) step('h1234);
    chk("R6 reset sin", s_sin, 0, 0);
    chk("R6 reset cos", s_cos, 0, 0);
    @(negedge clk) rst = ~RLV;
  endtask

  task automatic t_axes();
    logic [W-1:0] ax [4];
    ax[0] = 16'h0000; ax[1] = 16'h4000; ax[2] = 16'h8000; ax[3] = 16'hC000;
    for (int j = 0; j < 4 + LAT; j++) begin
      step(j < 4 ? ax[j] : 16'h0000);
      if (j >= LAT) begin
        chk("R7 axis cos", s_cos, (j - LAT) == 0 ? F : (j - LAT) == 2 ? -F : 0, TOL);
        chk("R7 axis sin", s_sin, (j - LAT) == 1 ? F : (j - LAT) == 3 ? -F : 0, TOL);
      end
    end
  endtask

  task automatic t_sweep();
    logic [W-1:0] a;
    bit fold;
    int n = 120;
    for (int j = 0; j < n + LAT; j++) begin
      a = W'(j * 20479 + 77);
      step(j < n ? a : 16'h0);
      if (j >= LAT) begin
        a = W'((j - LAT) * 20479 + 77);
        fold = a[W-1] ^ a[W-2];
        chk(fold ? "R4 cos" : "R1 cos", s_cos, ref_val(1'b0, a), TOL);
        chk(fold ? "R4 sin" : "R2 sin", s_sin, ref_val(1'b1, a), TOL);
        total++;
        if (s_sin > F + ITER + 4 || s_sin < -(F + ITER + 4) ||
            s_cos > F + ITER + 4 || s_cos < -(F + ITER + 4)) begin
          bad++;
          $display("FAIL R5 range act=%0d/%0d exp<=%0d", s_sin, s_cos, F + ITER + 4);
        end
      end
    end
  endtask

  task automatic t_latency();
    for (int j = 0; j < LAT + 2; j++) step(16'h0000);
    step(16'h8000);
    for (int j = 1; j < LAT - 1; j++) step(16'h8000);
    step(16'h8000);
    chk("R3 old angle still out", s_cos, F, TOL);
    step(16'h8000);
    chk("R3 new angle at latency", s_cos, -F, TOL);
  endtask

  task automatic t_repeat();
    int p_s, p_c;
    for (int j = 0; j < LAT; j++) step(W'(j * 3001));
    for (int j = 0; j < LAT + 3; j++) begin
      step(16'h2345);
      if (j == LAT) begin p_s = s_sin; p_c = s_cos; end
      if (j > LAT) begin
        chk("R8 repeat sin", s_sin, p_s, 0);
        chk("R8 repeat cos", s_cos, p_c, 0);
      end
    end
    chk("R1 repeat cos value", p_c, ref_val(1'b0, 16'h2345), TOL);
  endtask

  task automatic t_reset_mid();
    for (int j = 0; j < LAT + 2; j++) step(16'h1000);
    chk("R2 pre-reset sin", s_sin, ref_val(1'b1, 16'h1000), TOL);
    @(negedge clk);
    rst = RLV;
    #1;
    chk("R6 async sin", int'(sin_o), 0, 0);
    chk("R6 async cos", int'(cos_o), 0, 0);
    @(negedge clk) rst = ~RLV;
    for (int j = 0; j < LAT + 1; j++) step(16'hE000);
    chk("R1 after reset cos", s_cos, ref_val(1'b0, 16'hE000), TOL);
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset_start();
    t_axes();
    t_sweep();
    t_latency();
    t_repeat();
    t_reset_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule